// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Register Interface

This block gathers level-sensitive request lines, arranged as banks of 32 lines each, behind a single-cycle register bus. Every line has a mask bit. Software changes masks either by writing the whole mask word or through two write-only strobe registers: one sets mask bits and the other clears them. For each bank, a read-only pending word shows the requests that are currently asserted and not masked.

Each line has an 8-bit configuration register, and bits [7:2] of that register hold its priority. A combinational sorter chooses one line from the pending, unmasked set. The line with the lowest priority value wins, and a tie goes to the lower line number. Only lines whose priority value is strictly below the threshold register take part. When a line is chosen, the controller raises its single processor interrupt and freezes the chosen line number in the active-line register. Software services the line, removes the request at its source, and then writes the acknowledge bit. The interrupt output drops for one cycle, and a fresh sort follows.

A state machine controls the block. It has three states. ST_SRST counts out a reset sequence, ST_IDLE sorts, and ST_ACTIVE presents one interrupt. The transitions are as follows:
- Power-on reset or a soft-reset write moves the machine into ST_SRST from any state.
- ST_SRST moves to ST_IDLE when its counter expires.
- ST_IDLE moves to ST_ACTIVE when the sorter finds a qualifying line.
- ST_ACTIVE moves back to ST_IDLE on an acknowledge write.

While in ST_SRST, every register is held at its reset value and bus writes are dropped.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset completes, irq_out is 0, the reset-done flag (offset 0x14 bit 0) reads 1, every mask word reads 0xFFFFFFFF, the threshold (offset 0x68) reads 0xFF, the configuration word (offset 0x10) reads 0, and offset 0x00 reads {REV_MAJOR, REV_MINOR} in bits [7:4] and [3:0].
- R2: For bank b, the mask word sits at 0x84+0x20*b. Writing 1s at 0x8C+0x20*b sets those mask bits. Writing 1s at 0x88+0x20*b clears them. Zero bits in either write leave the mask unchanged.
- R3: The read-only word at 0x98+0x20*b equals the raw request lines of bank b ANDed with the inverse of that bank's mask.
- R4: Line i's configuration register is at 0x100+4*i, and its priority is bits [7:2]. Among qualifying lines, the lowest priority value wins, and equal values go to the lower line number.
- R5: A pending line qualifies only when its priority value is strictly below the 8-bit threshold. A threshold of 0xFF lets every line through.
- R6: irq_out rises on the clock edge after a qualifying line appears. While irq_out is high, offset 0x40 bits [6:0] report the chosen line and stay unchanged until the acknowledge, even if the line is later masked or dropped. Offset 0x40 reads 0 while irq_out is low.
- R7: A write to 0x48 with bit 0 set forces irq_out low on the following edge, and the next sort may raise it again one edge later. A write to 0x48 with bit 0 clear has no effect.
- R8: Writing 0x10 with bit 1 set starts a soft reset. The reset-done flag reads 0 until RST_CYCLES edges after the write and reads 1 from then on. Afterwards all masks are set, configuration registers, the threshold, protection, idle and autoidle are back at their reset values, and bit 1 reads 0.
- R9: While a reset is in progress, irq_out is 0 and bus writes are ignored.
- R10: The threshold (0x68), protection bit 0 (0x4C), idle bits [1:0] (0x50), autoidle bit 0 (0x10) and all 8 bits of each configuration register read back the values last written.
- R11: Reads of unimplemented or unaligned offsets return 0, and so do reads of the write-only set, clear and acknowledge registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; starts the reset sequence |
| irq_lines | input | 32*NUM_BANKS | Level-sensitive request lines |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
The acknowledge write and the arrival of a new request can land on the same clock edge. The bench provokes this while line 30 is active: in the same cycle it drops line 30, raises line 5 and writes the acknowledge. The bench first expects irq_out to be low on the cycle after that edge, which shows the acknowledge wins over the new request. On the following cycle it expects irq_out high with line 5 in the active register, which shows the new line was sorted without being lost. A second overlap is also tested: a soft-reset request while an interrupt is active must drop irq_out at once, and a register write issued during the reset count must leave no trace.

// File: rtl/lic_pkg.sv
`timescale 1ns/1ps
package lic_pkg;

    typedef enum logic [1:0] {
        ST_SRST   = 2'd0,
        ST_IDLE   = 2'd1,
        ST_ACTIVE = 2'd2
    } lic_state_e;

    typedef struct packed {
        logic       hit;
        logic [6:0] line;
    } lic_pick_t;

    // Word indices (byte offset / 4)
    localparam int W_REV     = 0;
    localparam int W_SYSCFG  = 4;
    localparam int W_SYSSTAT = 5;
    localparam int W_ACTIVE  = 16;
    localparam int W_CTRL    = 18;
    localparam int W_PROT    = 19;
    localparam int W_IDLE    = 20;
    localparam int W_THRESH  = 26;
    localparam int W_BANK0   = 33;
    localparam int W_CFG0    = 64;
    localparam int BANK_W    = 8;

    // Offsets inside one bank window, in words
    localparam int OFS_MASK  = 0;
    localparam int OFS_CLR   = 1;
    localparam int OFS_SET   = 2;
    localparam int OFS_PEND  = 5;

    localparam int BANK_LINES = 32;

endpackage

// File: rtl/lic_regs.sv
`timescale 1ns/1ps
module lic_regs
    import lic_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int ADDR_W    = 12,
    parameter int REV_MAJOR = 2,
    parameter int REV_MINOR = 1,
    localparam int LINES    = NUM_BANKS * BANK_LINES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    input  logic [LINES-1:0]      irq_lines,
    input  logic                  active_on,
    input  logic [6:0]            active_line,
    input  logic                  rst_done,
    output logic [31:0]           bus_rdata,
    output logic [LINES-1:0]      pend,
    output logic [LINES-1:0][5:0] prio,
    output logic [7:0]            thresh,
    output logic                  ack_pulse,
    output logic                  sr_req
);

    localparam logic [3:0] REV_HI = REV_MAJOR[3:0];
    localparam logic [3:0] REV_LO = REV_MINOR[3:0];

    logic [LINES-1:0] mask_q;
    logic [7:0]       cfg_q [LINES];
    logic [7:0]       thresh_q;
    logic             autoidle_q;
    logic             prot_q;
    logic [1:0]       idle_q;

    int   word_i;
    logic aligned;
    logic wr_en;

    always_comb begin
        word_i  = int'(bus_addr[ADDR_W-1:2]);
        aligned = (bus_addr[1:0] == 2'b00);
        wr_en   = bus_sel && bus_wr && aligned && !clr;
    end

    assign ack_pulse = wr_en && (word_i == W_CTRL) && bus_wdata[0];
    assign sr_req    = wr_en && (word_i == W_SYSCFG) && bus_wdata[1];

    // Register state: cleared by power-on reset and held while reset runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q     <= '1;
            thresh_q   <= 8'hFF;
            autoidle_q <= 1'b0;
            prot_q     <= 1'b0;
            idle_q     <= 2'b00;
            for (int i = 0; i < LINES; i++) cfg_q[i] <= 8'h00;
        end else if (clr) begin
            mask_q     <= '1;
            thresh_q   <= 8'hFF;
            autoidle_q <= 1'b0;
            prot_q     <= 1'b0;
            idle_q     <= 2'b00;
            for (int i = 0; i < LINES; i++) cfg_q[i] <= 8'h00;
        end else if (wr_en) begin
            if (word_i == W_SYSCFG) autoidle_q <= bus_wdata[0];
            if (word_i == W_PROT)   prot_q     <= bus_wdata[0];
            if (word_i == W_IDLE)   idle_q     <= bus_wdata[1:0];
            if (word_i == W_THRESH) thresh_q   <= bus_wdata[7:0];
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (word_i == W_BANK0 + b*BANK_W + OFS_MASK)
                    mask_q[b*BANK_LINES +: BANK_LINES] <= bus_wdata;
                if (word_i == W_BANK0 + b*BANK_W + OFS_CLR)
                    mask_q[b*BANK_LINES +: BANK_LINES] <=
                        mask_q[b*BANK_LINES +: BANK_LINES] & ~bus_wdata;
                if (word_i == W_BANK0 + b*BANK_W + OFS_SET)
                    mask_q[b*BANK_LINES +: BANK_LINES] <=
                        mask_q[b*BANK_LINES +: BANK_LINES] | bus_wdata;
            end
            for (int i = 0; i < LINES; i++) begin
                if (word_i == W_CFG0 + i) cfg_q[i] <= bus_wdata[7:0];
            end
        end
    end

    assign pend   = irq_lines & ~mask_q;
    assign thresh = thresh_q;

    always_comb begin
        for (int i = 0; i < LINES; i++) prio[i] = cfg_q[i][7:2];
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = 32'h0;
        if (bus_sel && !bus_wr && aligned) begin
            if (word_i == W_REV)     bus_rdata = {24'h0, REV_HI, REV_LO};
            if (word_i == W_SYSCFG)  bus_rdata = {31'h0, autoidle_q};
            if (word_i == W_SYSSTAT) bus_rdata = {31'h0, rst_done};
            if (word_i == W_ACTIVE && active_on) bus_rdata = {25'h0, active_line};
            if (word_i == W_PROT)    bus_rdata = {31'h0, prot_q};
            if (word_i == W_IDLE)    bus_rdata = {30'h0, idle_q};
            if (word_i == W_THRESH)  bus_rdata = {24'h0, thresh_q};
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (word_i == W_BANK0 + b*BANK_W + OFS_MASK)
                    bus_rdata = mask_q[b*BANK_LINES +: BANK_LINES];
                if (word_i == W_BANK0 + b*BANK_W + OFS_PEND)
                    bus_rdata = pend[b*BANK_LINES +: BANK_LINES];
            end
            for (int i = 0; i < LINES; i++) begin
                if (word_i == W_CFG0 + i) bus_rdata = {24'h0, cfg_q[i]};
            end
        end
    end

endmodule

// File: rtl/lic_sorter.sv
`timescale 1ns/1ps
module lic_sorter
    import lic_pkg::*;
#(
    parameter int LINES = 96
) (
    input  logic [LINES-1:0]      pend,
    input  logic [LINES-1:0][5:0] prio,
    input  logic [7:0]            thresh,
    output lic_pick_t             pick
);

    logic [5:0] best_prio;

    // Ascending scan with strict compare: ties keep the lower line number
    always_comb begin
        pick      = '0;
        best_prio = 6'h3F;
        for (int i = 0; i < LINES; i++) begin
            if (pend[i] && ({2'b00, prio[i]} < thresh) &&
                (!pick.hit || (prio[i] < best_prio))) begin
                pick.hit  = 1'b1;
                pick.line = 7'(i);
                best_prio = prio[i];
            end
        end
    end

endmodule

// File: rtl/lic_fsm.sv
`timescale 1ns/1ps
module lic_fsm
    import lic_pkg::*;
#(
    parameter int RST_CYCLES = 16,
    localparam int CW        = $clog2(RST_CYCLES) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sr_req,
    input  logic       ack,
    input  lic_pick_t  pick,
    output logic [6:0] active_line,
    output logic       irq_out,
    output logic       rst_done
);

    localparam logic [CW-1:0] CNT_LAST = CW'(RST_CYCLES - 1);

    lic_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [6:0]    line_q, line_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SRST;
            cnt_q   <= '0;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            line_q  <= line_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        line_d  = line_q;
        unique case (state_q)
            ST_SRST: begin
                if (cnt_q == CNT_LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_IDLE: begin
                if (pick.hit) begin
                    state_d = ST_ACTIVE;
                    line_d  = pick.line;
                end
            end
            ST_ACTIVE: begin
                if (ack) state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_SRST;
                cnt_d   = '0;
            end
        endcase
        if (sr_req) begin
            state_d = ST_SRST;
            cnt_d   = '0;
        end
    end

    // Outputs
    always_comb begin
        irq_out     = (state_q == ST_ACTIVE);
        rst_done    = (state_q != ST_SRST);
        active_line = line_q;
    end

endmodule

// File: rtl/lvl_irq_ctrl.sv
`timescale 1ns/1ps
module lvl_irq_ctrl
    import lic_pkg::*;
#(
    parameter int NUM_BANKS  = 3,
    parameter int ADDR_W     = 12,
    parameter int RST_CYCLES = 16,
    parameter int REV_MAJOR  = 2,
    parameter int REV_MINOR  = 1,
    localparam int LINES     = NUM_BANKS * BANK_LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_lines,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_out
);

    logic [LINES-1:0]      pend;
    logic [LINES-1:0][5:0] prio;
    logic [7:0]            thresh;
    logic                  ack_pulse;
    logic                  sr_req;
    logic                  rst_done;
    logic [6:0]            active_line;
    logic                  pend_any;
    lic_pick_t             pick;

    assign pend_any = |pend;

    lic_regs #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W),
        .REV_MAJOR (REV_MAJOR),
        .REV_MINOR (REV_MINOR)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (!rst_done),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .irq_lines   (irq_lines),
        .active_on   (irq_out),
        .active_line (active_line),
        .rst_done    (rst_done),
        .bus_rdata   (bus_rdata),
        .pend        (pend),
        .prio        (prio),
        .thresh      (thresh),
        .ack_pulse   (ack_pulse),
        .sr_req      (sr_req)
    );

    lic_sorter #(
        .LINES (LINES)
    ) u_sorter (
        .pend   (pend),
        .prio   (prio),
        .thresh (thresh),
        .pick   (pick)
    );

    lic_fsm #(
        .RST_CYCLES (RST_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sr_req      (sr_req),
        .ack         (ack_pulse),
        .pick        (pick),
        .active_line (active_line),
        .irq_out     (irq_out),
        .rst_done    (rst_done)
    );

endmodule

// File: rtl/lic_checks.sv
`timescale 1ns/1ps
module lic_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_out,
    input logic       ack,
    input logic       sr_req,
    input logic       rst_done,
    input logic       pend_any,
    input logic [6:0] active_line
);

    // R7: an acknowledge while presenting drops the output on the next edge
    p_ack_drops_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && ack) |=> !irq_out)
        else $error("p_ack_drops_irq_r7");

    // R6: the presented line is frozen until acknowledge or soft reset
    p_line_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !ack && !sr_req) |=> (irq_out && active_line == $past(active_line)))
        else $error("p_line_held_r6");

    // R6: the output only rises when something was pending
    p_rise_needs_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(pend_any))
        else $error("p_rise_needs_pend_r6");

    // R9: no interrupt while the reset count runs
    p_reset_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_done |-> !irq_out)
        else $error("p_reset_quiet_r9");

    // R8: a soft-reset request clears the done flag on the next edge
    p_srst_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_req |=> !rst_done)
        else $error("p_srst_enter_r8");

endmodule

bind lvl_irq_ctrl lic_checks u_lic_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_out     (irq_out),
    .ack         (ack_pulse),
    .sr_req      (sr_req),
    .rst_done    (rst_done),
    .pend_any    (pend_any),
    .active_line (active_line)
);

// File: tb/test_lvl_irq_ctrl.sv
`timescale 1ns/1ps
module test_lvl_irq_ctrl;

    localparam int NB    = 3;
    localparam int LINES = NB * 32;
    localparam int RST   = 16;

    localparam logic [11:0] A_REV    = 12'h000;
    localparam logic [11:0] A_SYSCFG = 12'h010;
    localparam logic [11:0] A_STAT   = 12'h014;
    localparam logic [11:0] A_ACTIVE = 12'h040;
    localparam logic [11:0] A_CTRL   = 12'h048;
    localparam logic [11:0] A_PROT   = 12'h04C;
    localparam logic [11:0] A_IDLE   = 12'h050;
    localparam logic [11:0] A_THR    = 12'h068;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LINES-1:0] lines = '0;
    logic             sel = 1'b0;
    logic             wen = 1'b0;
    logic [11:0]      addr = '0;
    logic [31:0]      wdata = '0;
    logic [31:0]      rdata;
    logic             irq;

    int n_checks = 0;
    int n_err    = 0;

    always #4 clk = ~clk;

    lvl_irq_ctrl #(
        .NUM_BANKS (NB), .ADDR_W (12), .RST_CYCLES (RST),
        .REV_MAJOR (2), .REV_MINOR (1)
    ) i_lvl_irq_ctrl (
        .clk (clk), .rst_n (rst_n), .irq_lines (lines),
        .bus_sel (sel), .bus_wr (wen), .bus_addr (addr),
        .bus_wdata (wdata), .bus_rdata (rdata), .irq_out (irq)
    );

    function automatic logic [11:0] bank_a(input int b, input int ofs);
        return 12'(32'h84 + b * 32 + ofs);
    endfunction

    function automatic logic [11:0] cfg_a(input int i);
        return 12'(32'h100 + 4 * i);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // All bus tasks start at a falling edge and return one cycle later
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        sel = 1'b1; wen = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wen = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        sel = 1'b1; wen = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic rdchk(input string req, input string what,
                         input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, what, d, exp);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(RST + 3);
        chk("R1", "irq_out after reset", {31'h0, irq}, 32'h0);
        rdchk("R1", "reset done flag", A_STAT, 32'h1);
        rdchk("R1", "mask bank0", bank_a(0, 0), 32'hFFFF_FFFF);
        rdchk("R1", "mask bank2", bank_a(2, 0), 32'hFFFF_FFFF);
        rdchk("R1", "threshold", A_THR, 32'hFF);
        rdchk("R1", "revision", A_REV, 32'h21);
        rdchk("R1", "sysconfig", A_SYSCFG, 32'h0);
    endtask

    task automatic t_mask;
        wr(bank_a(0, 4), 32'hF0);
        rdchk("R2", "clear strobe", bank_a(0, 0), 32'hFFFF_FF0F);
        wr(bank_a(0, 8), 32'h10);
        rdchk("R2", "set strobe", bank_a(0, 0), 32'hFFFF_FF1F);
        wr(bank_a(0, 4), 32'h0);
        wr(bank_a(0, 8), 32'h0);
        rdchk("R2", "zero strobes keep mask", bank_a(0, 0), 32'hFFFF_FF1F);
        for (int b = 0; b < NB; b++) wr(bank_a(b, 4), 32'hFFFF_FFFF);
        rdchk("R2", "bank2 unmasked", bank_a(2, 0), 32'h0);
    endtask

    task automatic t_pending;
        wr(bank_a(1, 8), 32'h20);
        lines[3] = 1'b1; lines[37] = 1'b1; lines[69] = 1'b1;
        rdchk("R3", "pending bank0", bank_a(0, 20), 32'h8);
        rdchk("R3", "pending bank1 masked", bank_a(1, 20), 32'h0);
        rdchk("R3", "pending bank2", bank_a(2, 20), 32'h20);
        lines = '0;
        wr(A_CTRL, 32'h1);
        tick(2);
        chk("R3", "irq_out idle after cleanup", {31'h0, irq}, 32'h0);
        wr(bank_a(1, 4), 32'h20);
    endtask

    task automatic t_sort;
        wr(cfg_a(10), 32'h14);
        wr(cfg_a(40), 32'h08);
        wr(cfg_a(70), 32'h08);
        lines[10] = 1'b1; lines[40] = 1'b1; lines[70] = 1'b1;
        tick(1);
        chk("R6", "irq_out one edge after request", {31'h0, irq}, 32'h1);
        rdchk("R4", "lowest priority value wins", A_ACTIVE, 32'd40);
        wr(bank_a(1, 8), 32'h100);
        chk("R6", "irq_out held after masking", {31'h0, irq}, 32'h1);
        rdchk("R6", "active held after masking", A_ACTIVE, 32'd40);
        wr(A_CTRL, 32'h0);
        chk("R7", "bit0 clear is not an acknowledge", {31'h0, irq}, 32'h1);
        wr(A_CTRL, 32'h1);
        chk("R7", "irq_out low after acknowledge", {31'h0, irq}, 32'h0);
        tick(1);
        chk("R7", "irq_out raised by next sort", {31'h0, irq}, 32'h1);
        rdchk("R4", "next line after masked one", A_ACTIVE, 32'd70);
        lines[70] = 1'b0;
        wr(A_CTRL, 32'h1);
        tick(1);
        rdchk("R4", "remaining line", A_ACTIVE, 32'd10);
        lines = '0;
        wr(A_CTRL, 32'h1);
        tick(2);
        chk("R7", "irq_out low when nothing pending", {31'h0, irq}, 32'h0);
        rdchk("R6", "active reads 0 when idle", A_ACTIVE, 32'h0);
        wr(bank_a(1, 4), 32'h100);
    endtask

    task automatic t_tie;
        wr(cfg_a(20), 32'h0C);
        wr(cfg_a(50), 32'h0C);
        lines[20] = 1'b1; lines[50] = 1'b1;
        tick(1);
        rdchk("R4", "tie to lower line", A_ACTIVE, 32'd20);
        lines[20] = 1'b0;
        wr(A_CTRL, 32'h1);
        tick(1);
        rdchk("R4", "tie loser next", A_ACTIVE, 32'd50);
        lines = '0;
        wr(A_CTRL, 32'h1);
        tick(2);
    endtask

    task automatic t_thresh;
        wr(cfg_a(12), 32'h24);
        wr(A_THR, 32'h09);
        lines[12] = 1'b1;
        tick(2);
        chk("R5", "priority equal to threshold blocked", {31'h0, irq}, 32'h0);
        wr(A_THR, 32'h0A);
        tick(1);
        chk("R5", "priority below threshold passes", {31'h0, irq}, 32'h1);
        rdchk("R5", "filtered line presented", A_ACTIVE, 32'd12);
        lines = '0;
        wr(A_CTRL, 32'h1);
        wr(A_THR, 32'hFF);
        tick(2);
    endtask

    task automatic t_overlap;
        lines[30] = 1'b1;
        tick(1);
        rdchk("R6", "line 30 presented", A_ACTIVE, 32'd30);
        lines[30] = 1'b0;
        lines[5]  = 1'b1;
        wr(A_CTRL, 32'h1);
        chk("R7", "ack wins over new request", {31'h0, irq}, 32'h0);
        tick(1);
        chk("R7", "new request sorted after ack", {31'h0, irq}, 32'h1);
        rdchk("R7", "new line presented", A_ACTIVE, 32'd5);
        lines = '0;
        wr(A_CTRL, 32'h1);
        tick(2);
    endtask

    task automatic t_regs;
        wr(A_THR, 32'h33);
        wr(A_PROT, 32'h1);
        wr(A_IDLE, 32'h3);
        wr(cfg_a(95), 32'hAB);
        wr(A_SYSCFG, 32'h1);
        rdchk("R10", "threshold retained", A_THR, 32'h33);
        rdchk("R10", "protection retained", A_PROT, 32'h1);
        rdchk("R10", "idle retained", A_IDLE, 32'h3);
        rdchk("R10", "config line 95 retained", cfg_a(95), 32'hAB);
        rdchk("R10", "autoidle retained", A_SYSCFG, 32'h1);
        wr(A_THR, 32'hFF);
    endtask

    task automatic t_unimpl;
        rdchk("R11", "hole 0x020", 12'h020, 32'h0);
        rdchk("R11", "hole 0x080", 12'h080, 32'h0);
        rdchk("R11", "beyond configs 0x3FC", 12'h3FC, 32'h0);
        rdchk("R11", "clear strobe reads 0", bank_a(0, 4), 32'h0);
        rdchk("R11", "ack register reads 0", A_CTRL, 32'h0);
        rdchk("R11", "unaligned mask read", 12'h086, 32'h0);
    endtask

    task automatic t_softrst;
        logic [31:0] d;
        int zeros;
        wr(cfg_a(10), 32'h14);
        wr(A_PROT, 32'h1);
        lines[7] = 1'b1;
        tick(1);
        chk("R9", "line 7 presented before reset", {31'h0, irq}, 32'h1);
        wr(A_SYSCFG, 32'h3);
        chk("R9", "irq_out low at reset start", {31'h0, irq}, 32'h0);
        wr(A_THR, 32'h11);
        zeros = 0;
        for (int k = 0; k < 100; k++) begin
            rd(A_STAT, d);
            if (d[0]) break;
            zeros++;
        end
        chk("R8", "cycles until done flag", 32'(zeros), 32'(RST - 1));
        rdchk("R9", "write during reset ignored", A_THR, 32'hFF);
        rdchk("R8", "masks set", bank_a(0, 0), 32'hFFFF_FFFF);
        rdchk("R8", "sysconfig cleared", A_SYSCFG, 32'h0);
        rdchk("R8", "config cleared", cfg_a(10), 32'h0);
        rdchk("R8", "protection cleared", A_PROT, 32'h0);
        chk("R8", "irq_out low after reset", {31'h0, irq}, 32'h0);
        lines = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_mask();
        t_pending();
        t_sort();
        t_tie();
        t_thresh();
        t_overlap();
        t_regs();
        t_unimpl();
        t_softrst();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule